// File: doc/BRIEF.md
# CAN Receive Mailbox Acceptance Filter

This block sits behind a CAN protocol engine that has already decoded a received frame into an identifier, an extended-format flag, a data length code and up to eight data bytes. When the engine presents a frame, the block compares its identifier with the identifiers held by a bank of receive mailboxes. Only mailboxes that are enabled and set to the same format as the frame take part. When more than one mailbox matches, the one with the lowest index wins.

The winning mailbox receives the frame packed into eight 16-bit words, together with a 16-bit timestamp taken from a free-running counter. Its interrupt line is raised. If that line was still pending, the mailbox is overwritten anyway and a sticky overrun flag is set for it. A frame that matches nothing leaves no trace.

Software configures each mailbox with one write that carries the identifier, the format flag and the enable. It reads back any word of any mailbox through a registered read port, and clears interrupt and overrun flags with a bit mask.

Top module: `can_rx_mbx_filter`

## Requirements
- R1: After reset, `irq_pend` and `ovr_flag` are all zero, every mailbox is disabled, and every stored word reads as 0x0000.
- R2: A mailbox set to standard format (`cfg_ide`=0) matches a frame with `frm_ide`=0 when `frm_id[10:0]` equals its identifier bits [10:0]. Frame identifier bits [28:11] are ignored for such a match.
- R3: A mailbox set to extended format (`cfg_ide`=1) matches a frame with `frm_ide`=1 only when all 29 identifier bits are equal.
- R4: A mailbox never matches when it is disabled (`cfg_en`=0), or when its format flag differs from `frm_ide`.
- R5: When several mailboxes match, only the one with the lowest index is written and flagged.
- R6: The accepted frame is stored at the clock edge that samples `frm_valid`, using this word layout:
  - word 0 = {ide, 2'b00, id[28:16]}
  - word 1 = id[15:0]
  - word 2 = {12'h000, dlc}
  - words 3 to 6 = byte pairs {byte 2k, byte 2k+1} for k = 0..3, where byte 0 is `frm_data[63:56]`
  - word 7 = timestamp

  The identifier is stored with bits [28:11] forced to zero for standard frames.
- R7: Data bytes at positions at or above min(dlc, 8) are stored as zero. A dlc above 8 is kept unchanged in word 2, and all eight bytes are stored.
- R8: The timestamp equals the number of rising clock edges between reset release and the edge that accepts the frame.
- R9: An accepted frame sets the winning mailbox's `irq_pend` bit at the accepting edge. A cycle with `irq_clr_we`=1 clears every `irq_pend` and `ovr_flag` bit set in `irq_clr_mask`.
- R10: A frame accepted into a mailbox whose `irq_pend` bit is already set overwrites the mailbox and sets its `ovr_flag` bit. The `ovr_flag` bit stays set until it is cleared.
- R11: A frame that matches no mailbox changes neither flags nor stored words.
- R12: `rd_data` shows the word selected by `rd_idx` and `rd_word` one clock after `rd_en`, and holds its value while `rd_en` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Write one mailbox configuration |
| cfg_idx | input | 5 | Mailbox being configured |
| cfg_en | input | 1 | Receive enable of that mailbox |
| cfg_ide | input | 1 | 1 = extended, 0 = standard format |
| cfg_id | input | 29 | Mailbox identifier |
| frm_valid | input | 1 | Decoded frame present this cycle |
| frm_ide | input | 1 | Frame format flag |
| frm_id | input | 29 | Frame identifier |
| frm_dlc | input | 4 | Frame data length code |
| frm_data | input | 64 | Frame data, byte 0 in bits 63:56 |
| rd_en | input | 1 | Read request |
| rd_idx | input | 5 | Mailbox to read |
| rd_word | input | 3 | Word within the mailbox |
| rd_data | output | 16 | Registered read data |
| irq_clr_we | input | 1 | Apply the clear mask |
| irq_clr_mask | input | 32 | Flags to clear, one bit per mailbox |
| irq_pend | output | 32 | Per-mailbox message-arrived interrupt |
| ovr_flag | output | 32 | Per-mailbox sticky overrun flag |

## Verification
Directed frames cover four cases:
- A standard frame with noise in its upper identifier bits, which separates an 11-bit compare from a 29-bit one.
- An extended identifier that differs only in its least significant bit.
- Format-mismatched and disabled mailboxes that share identifier bits with the frame.
- Duplicate identifiers in two mailboxes, which exposes the lowest-index priority.

Length codes of 3, 0 and 12 show whether padding and clamping are done correctly. A second frame into a pending mailbox tells overwrite-with-overrun apart from either dropping the frame or silently overwriting it. A long random run then follows, with mailbox configurations drawn so that identifiers repeat and formats collide. It mixes targeted, flipped-format and fully random frames with random clears, and compares flags and read-back words with a bench model.

// File: rtl/can_mbx_pkg.sv
package can_mbx_pkg;
   localparam int ID_W    = 29;
   localparam int STD_W   = 11;
   localparam int HW_W    = 16;
   localparam int N_WORDS = 8;
   localparam int N_BYTES = 8;

   typedef struct packed {
      logic            en;
      logic            ide;
      logic [ID_W-1:0] id;
   } mbx_cfg_t;

   typedef struct packed {
      logic                  ide;
      logic [ID_W-1:0]       id;
      logic [3:0]            dlc;
      logic [8*N_BYTES-1:0]  data;
   } rx_frame_t;
endpackage

// File: rtl/mbx_match.sv
module mbx_match
   import can_mbx_pkg::*;
#(
   parameter int N_MBX = 32,
   localparam int IDX_W = $clog2(N_MBX)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  mbx_cfg_t             cfg [N_MBX],
   input  rx_frame_t            frm,
   output logic [N_MBX-1:0]     hit_oh,
   output logic [IDX_W-1:0]     hit_idx,
   output logic                 any_hit
);
   logic [N_MBX-1:0] raw;

   for (genvar i = 0; i < N_MBX; i++) begin : g_cmp
      logic same_id;
      assign same_id = cfg[i].ide ? (cfg[i].id == frm.id)
                                  : (cfg[i].id[STD_W-1:0] == frm.id[STD_W-1:0]);
      assign raw[i]  = cfg[i].en && (cfg[i].ide == frm.ide) && same_id;
   end

   // isolate lowest set bit
   assign hit_oh  = raw & (~raw + 1'b1);
   assign any_hit = |raw;

   always_comb begin
      hit_idx = '0;
      for (int i = N_MBX - 1; i >= 0; i--)
         if (raw[i]) hit_idx = IDX_W'(i);
   end

   AST_ONE_WINNER: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_oh) && (any_hit == (hit_oh != '0))); // R5
endmodule

// File: rtl/mbx_store.sv
module mbx_store
   import can_mbx_pkg::*;
#(
   parameter int N_MBX    = 32,
   parameter int TS_W     = 16,
   parameter bit ZERO_PAD = 1'b1,
   localparam int IDX_W   = $clog2(N_MBX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [IDX_W-1:0]  wr_idx,
   input  rx_frame_t         frm,
   input  logic [TS_W-1:0]   ts,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [2:0]        rd_word,
   output logic [HW_W-1:0]   rd_data
);
   logic [HW_W-1:0] mem [N_MBX][N_WORDS];
   logic [HW_W-1:0] nw  [N_WORDS];
   logic [7:0]      byt [N_BYTES];
   logic [ID_W-1:0] idm;
   logic [3:0]      nbytes;

   assign idm    = frm.ide ? frm.id : {{(ID_W-STD_W){1'b0}}, frm.id[STD_W-1:0]};
   assign nbytes = (frm.dlc > 4'd8) ? 4'd8 : frm.dlc;

   for (genvar b = 0; b < N_BYTES; b++) begin : g_byte
      if (ZERO_PAD) begin : g_pad
         assign byt[b] = (4'(b) < nbytes) ? frm.data[8*(N_BYTES-b)-1 -: 8] : 8'h00;
      end else begin : g_raw
         assign byt[b] = frm.data[8*(N_BYTES-b)-1 -: 8];
      end
   end

   always_comb begin
      nw[0] = {frm.ide, 2'b00, idm[ID_W-1:16]};
      nw[1] = idm[15:0];
      nw[2] = {12'h000, frm.dlc};
      for (int k = 0; k < 4; k++) nw[3+k] = {byt[2*k], byt[2*k+1]};
      nw[7] = HW_W'(ts);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int m = 0; m < N_MBX; m++)
            for (int w = 0; w < N_WORDS; w++) mem[m][w] <= '0;
         rd_data <= '0;
      end else begin
         if (wr_en)
            for (int w = 0; w < N_WORDS; w++) mem[wr_idx][w] <= nw[w];
         if (rd_en) rd_data <= mem[rd_idx][rd_word];
      end
   end
endmodule

// File: rtl/can_rx_mbx_filter.sv
module can_rx_mbx_filter
   import can_mbx_pkg::*;
#(
   parameter int N_MBX    = 32,
   parameter int TS_W     = 16,
   parameter bit ZERO_PAD = 1'b1,
   localparam int IDX_W   = $clog2(N_MBX)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [IDX_W-1:0]  cfg_idx,
   input  logic              cfg_en,
   input  logic              cfg_ide,
   input  logic [28:0]       cfg_id,
   input  logic              frm_valid,
   input  logic              frm_ide,
   input  logic [28:0]       frm_id,
   input  logic [3:0]        frm_dlc,
   input  logic [63:0]       frm_data,
   input  logic              rd_en,
   input  logic [IDX_W-1:0]  rd_idx,
   input  logic [2:0]        rd_word,
   output logic [15:0]       rd_data,
   input  logic              irq_clr_we,
   input  logic [N_MBX-1:0]  irq_clr_mask,
   output logic [N_MBX-1:0]  irq_pend,
   output logic [N_MBX-1:0]  ovr_flag
);
   if (N_MBX < 2 || N_MBX > 64) begin : g_chk_n
      $error("N_MBX out of range");
   end
   if (TS_W < 1 || TS_W > HW_W) begin : g_chk_ts
      $error("TS_W must fit one halfword");
   end

   mbx_cfg_t          cfg_q [N_MBX];
   rx_frame_t         frm;
   logic [TS_W-1:0]   ts_q;
   logic [N_MBX-1:0]  hit_oh, hit_v, clr_v;
   logic [IDX_W-1:0]  hit_idx;
   logic              any_hit;

   assign frm   = '{ide: frm_ide, id: frm_id, dlc: frm_dlc, data: frm_data};
   assign hit_v = frm_valid ? hit_oh : '0;
   assign clr_v = irq_clr_we ? irq_clr_mask : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int m = 0; m < N_MBX; m++) cfg_q[m] <= '0;
         ts_q     <= '0;
         irq_pend <= '0;
         ovr_flag <= '0;
      end else begin
         ts_q <= ts_q + 1'b1;
         if (cfg_we && (int'(cfg_idx) < N_MBX))
            cfg_q[cfg_idx] <= '{en: cfg_en, ide: cfg_ide, id: cfg_id};
         irq_pend <= (irq_pend & ~clr_v) | hit_v;
         ovr_flag <= (ovr_flag & ~clr_v) | (hit_v & irq_pend & ~clr_v);
      end
   end

   mbx_match #(.N_MBX(N_MBX)) u_match (
      .clk(clk), .rst_n(rst_n), .cfg(cfg_q), .frm(frm),
      .hit_oh(hit_oh), .hit_idx(hit_idx), .any_hit(any_hit)
   );

   mbx_store #(.N_MBX(N_MBX), .TS_W(TS_W), .ZERO_PAD(ZERO_PAD)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(frm_valid && any_hit), .wr_idx(hit_idx),
      .frm(frm), .ts(ts_q), .rd_en(rd_en), .rd_idx(rd_idx), .rd_word(rd_word),
      .rd_data(rd_data)
   );

   AST_HIT_SETS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && any_hit) |=> ((irq_pend & $past(hit_oh)) == $past(hit_oh))); // R9
   AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      ((irq_pend & ~$past(irq_pend)) != '0) |-> $past(frm_valid)); // R9
   AST_OVR_NEEDS_PEND: assert property (@(posedge clk) disable iff (!rst_n)
      (ovr_flag & ~$past(ovr_flag) & ~$past(irq_pend)) == '0); // R10
   AST_MISS_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (frm_valid && !any_hit && !irq_clr_we) |=> ($stable(irq_pend) && $stable(ovr_flag))); // R11
endmodule

// File: tb/can_rx_mbx_filter_tb.sv
module can_rx_mbx_filter_tb;
   localparam int CLK_P = 10;
   localparam int N = 32;

   logic        clk = 1'b0, rst_n = 1'b0;
   logic        cfg_we = 0, cfg_en = 0, cfg_ide = 0;
   logic [4:0]  cfg_idx = '0;
   logic [28:0] cfg_id = '0;
   logic        frm_valid = 0, frm_ide = 0;
   logic [28:0] frm_id = '0;
   logic [3:0]  frm_dlc = '0;
   logic [63:0] frm_data = '0;
   logic        rd_en = 0;
   logic [4:0]  rd_idx = '0;
   logic [2:0]  rd_word = '0;
   logic [15:0] rd_data;
   logic        irq_clr_we = 0;
   logic [31:0] irq_clr_mask = '0;
   logic [31:0] irq_pend, ovr_flag;

   int checks = 0, fails = 0;
   logic [15:0] bc;

   logic        m_en [N], m_ide [N];
   logic [28:0] m_id [N];
   logic [15:0] m_mem [N][8];
   logic [31:0] m_pend, m_ovr;

   always #(CLK_P/2) clk = ~clk;

   always @(posedge clk or negedge rst_n)
      if (!rst_n) bc <= '0; else bc <= bc + 1'b1;

   can_rx_mbx_filter u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_en(cfg_en),
      .cfg_ide(cfg_ide), .cfg_id(cfg_id), .frm_valid(frm_valid), .frm_ide(frm_ide),
      .frm_id(frm_id), .frm_dlc(frm_dlc), .frm_data(frm_data), .rd_en(rd_en),
      .rd_idx(rd_idx), .rd_word(rd_word), .rd_data(rd_data), .irq_clr_we(irq_clr_we),
      .irq_clr_mask(irq_clr_mask), .irq_pend(irq_pend), .ovr_flag(ovr_flag)
   );

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic int model_match(input logic [28:0] id, input logic ide);
      for (int i = 0; i < N; i++)
         if (m_en[i] && m_ide[i] == ide &&
             (ide ? (m_id[i] == id) : (m_id[i][10:0] == id[10:0])))
            return i;
      return -1;
   endfunction

   function automatic logic [15:0] model_word(input int w, input logic [28:0] id, input logic ide,
                                              input logic [3:0] dlc, input logic [63:0] d,
                                              input logic [15:0] ts);
      logic [28:0] idm;
      logic [7:0]  by [8];
      int n;
      idm = ide ? id : {18'h0, id[10:0]};
      n = (dlc > 8) ? 8 : int'(dlc);
      for (int b = 0; b < 8; b++) by[b] = (b < n) ? d[63-8*b -: 8] : 8'h00;
      case (w)
         0: return {ide, 2'b00, idm[28:16]};
         1: return idm[15:0];
         2: return {12'h000, dlc};
         7: return ts;
         default: return {by[2*(w-3)], by[2*(w-3)+1]};
      endcase
   endfunction

   task automatic write_cfg(input int idx, input logic en, input logic ide, input logic [28:0] id);
      @(negedge clk);
      cfg_we = 1; cfg_idx = 5'(idx); cfg_en = en; cfg_ide = ide; cfg_id = id;
      @(negedge clk);
      cfg_we = 0;
      m_en[idx] = en; m_ide[idx] = ide; m_id[idx] = id;
   endtask

   task automatic send(input string tag, input logic [28:0] id, input logic ide,
                       input logic [3:0] dlc, input logic [63:0] d);
      int k;
      @(negedge clk);
      frm_valid = 1; frm_id = id; frm_ide = ide; frm_dlc = dlc; frm_data = d;
      k = model_match(id, ide);
      if (k >= 0) begin
         if (m_pend[k]) m_ovr[k] = 1'b1;
         m_pend[k] = 1'b1;
         for (int w = 0; w < 8; w++) m_mem[k][w] = model_word(w, id, ide, dlc, d, bc);
      end
      @(negedge clk);
      frm_valid = 0;
      check({tag, " pend"}, 64'(irq_pend), 64'(m_pend));
      check({tag, " ovr"}, 64'(ovr_flag), 64'(m_ovr));
   endtask

   task automatic clear(input logic [31:0] mask);
      @(negedge clk);
      irq_clr_we = 1; irq_clr_mask = mask;
      @(negedge clk);
      irq_clr_we = 0;
      m_pend &= ~mask; m_ovr &= ~mask;
      check("R9 clear pend", 64'(irq_pend), 64'(m_pend));
      check("R9 clear ovr", 64'(ovr_flag), 64'(m_ovr));
   endtask

   task automatic read_chk(input string tag, input int idx, input int w);
      @(negedge clk);
      rd_en = 1; rd_idx = 5'(idx); rd_word = 3'(w);
      @(negedge clk);
      rd_en = 0;
      check(tag, 64'(rd_data), 64'(m_mem[idx][w]));
   endtask

   initial begin
      #(CLK_P * 150000);
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      logic [15:0] hold;
      void'($urandom(32'd4242));
      for (int i = 0; i < N; i++) begin
         m_en[i] = 0; m_ide[i] = 0; m_id[i] = '0;
         for (int w = 0; w < 8; w++) m_mem[i][w] = '0;
      end
      m_pend = '0; m_ovr = '0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      check("R1 pend reset", 64'(irq_pend), 64'h0);
      check("R1 ovr reset", 64'(ovr_flag), 64'h0);
      read_chk("R1 word reset", 0, 0);
      send("R1 R4 all disabled", 29'h0, 1'b0, 4'd0, 64'h0);

      write_cfg(3, 1, 0, 29'h123);
      write_cfg(5, 1, 0, 29'h123);
      send("R2 R5 std dup", {18'h2A5F3, 11'h123}, 1'b0, 4'd3, 64'hA1B2C3D4E5F60718);
      read_chk("R2 std id w0", 3, 0);
      read_chk("R2 std id w1", 3, 1);
      read_chk("R7 dlc w2", 3, 2);
      read_chk("R7 pad w3", 3, 3);
      read_chk("R7 pad w4", 3, 4);
      read_chk("R5 loser untouched", 5, 1);

      write_cfg(7, 1, 1, 29'h1ABCDE01);
      send("R3 ext lsb miss", 29'h1ABCDE00, 1'b1, 4'd8, 64'h1);
      send("R4 format mismatch", 29'h1ABCDE01, 1'b0, 4'd8, 64'h2);
      send("R3 ext hit", 29'h1ABCDE01, 1'b1, 4'd12, 64'h0123456789ABCDEF);
      read_chk("R6 ext w0", 7, 0);
      read_chk("R6 ext w1", 7, 1);
      read_chk("R7 dlc12 w2", 7, 2);
      read_chk("R7 dlc12 w6", 7, 6);
      read_chk("R8 timestamp", 7, 7);

      write_cfg(9, 0, 0, 29'h055);
      send("R4 disabled", 29'h055, 1'b0, 4'd1, 64'hFF00000000000000);
      read_chk("R11 disabled untouched", 9, 3);

      send("R10 overrun", 29'h123, 1'b0, 4'd0, 64'hFFFFFFFFFFFFFFFF);
      read_chk("R10 overwritten w2", 3, 2);
      read_chk("R7 dlc0 w3", 3, 3);
      clear(32'h0000_0008);
      clear(32'hFFFF_FFFF);

      @(negedge clk);
      hold = rd_data;
      @(negedge clk);
      check("R12 hold without rd_en", 64'(rd_data), 64'(hold));

      for (int i = 0; i < N; i++) begin
         logic [28:0] rid;
         rid = (i > 4 && $urandom_range(0, 3) == 0) ? m_id[$urandom_range(0, i - 1)] : 29'($urandom);
         write_cfg(i, ($urandom_range(0, 6) != 0), 1'($urandom), rid);
      end
      for (int t = 0; t < 400; t++) begin
         int k, sel;
         logic [28:0] id;
         logic ide;
         k = $urandom_range(0, N - 1);
         sel = $urandom_range(0, 9);
         id = m_id[k]; ide = m_ide[k];
         if (!ide) id[28:11] = 18'($urandom);
         if (sel == 0) ide = ~ide;
         if (sel == 1) begin id = 29'($urandom); ide = 1'($urandom); end
         send("R2 R3 R5 R10 random", id, ide, 4'($urandom), {$urandom, $urandom});
         if ($urandom_range(0, 4) == 0) clear($urandom);
         if (t % 8 == 0) begin
            int r;
            r = $urandom_range(0, N - 1);
            for (int w = 0; w < 8; w++) read_chk("R6 R8 R11 random read", r, w);
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule